// File: doc/BRIEF.md
# Multi-Channel PWM Register Peripheral

This block generates several independent pulse-width-modulated outputs and keeps their settings in a small bank of 32-bit registers on a plain write-strobe bus. A control word holds one run bit per channel. Software changes that word by writing it directly, or by writing a mask to one of three alias addresses that set, clear or invert only the masked bits. The alias path avoids a read-modify-write sequence.

Each channel owns two registers. The edge register places the count where the output enters its active phase and the count where it leaves it. The period register holds the terminal count, a 2-bit level code for each phase, and a prescaler exponent. The channel counter steps once every 2^exponent clocks, runs from zero to the terminal count inclusive, and then wraps. New settings reach the running channel only at a wrap, so no period is cut short or stretched by a write. A stopped channel holds its counter and prescaler at zero and drives its inactive level.

Reads are combinational: `bus_rdata` reflects the register selected by `bus_addr` in the same cycle.

Top module: `pwm_bank`

## Requirements
- R1: After reset, the control word, all edge fields and all period fields read as zero, and every `pwm_oe` bit is low.
- R2: A write to offset 0x00 replaces the control word. Bit n of the control word runs channel n. Bits at or above the channel count are not stored and read as zero.
- R3: A write to offset 0x04 sets the masked control bits, a write to 0x08 clears them, and a write to 0x0C inverts them. Unmasked bits are left unchanged. A read of any of the three alias offsets returns the control word.
- R4: Channel n has an edge register at 0x10+0x20·n and a period register at 0x20+0x20·n. In the edge register, bits 15:0 hold the active edge and bits 31:16 hold the inactive edge. In the period register, bits 15:0 hold the terminal count, 17:16 the active-phase level code, 19:18 the inactive-phase level code, and 22:20 the prescaler exponent. Both registers read back their stored fields, and the period register returns zero in bits 31:23.
- R5: A running channel counts 0,1,…,P,0,… with P the terminal count, so one period lasts P+1 counter steps. Its output is in the active phase when the count is at least the active edge and below the inactive edge.
- R6: With exponent e, the channel counter advances once every 2^e clocks, for e = 0 through 7.
- R7: Level code 3 drives high. Codes 1 and 2 drive low. In all three cases `pwm_oe` is high. Code 0 lowers `pwm_oe`, and `pwm_out` is then 0.
- R8: If the inactive edge is equal to or greater than the terminal count, every count at or after the active edge is in the active phase. With the active edge at 0, this gives 100% duty.
- R9: If the inactive edge equals the active edge, the output stays in the inactive phase for the whole period (0% duty).
- R10: A stopped channel holds its counter and prescaler at zero and drives the level of its stored inactive-phase code. In the first cycle after the write that starts it, the channel is at count 0.
- R11: Edge, period, level and exponent values written while a channel runs take effect at the next wrap from count P to 0. Until then the channel keeps its previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data or alias mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH | Output level per channel |
| pwm_oe | output | NCH | Output-enable per channel, low for level code 0 |

## Verification
The assertions assume that each write strobe lasts a single cycle and carries a mapped offset. They also assume that the exponent held by a channel changes only at a wrap or while the channel is stopped. The prescaler bound depends on that assumption. In most cases the stimulus sets up a channel's registers while it is stopped, then starts it with a set-alias write and waits a whole number of periods before stopping it. The one exception checks R11. In that case the writes to a running channel are placed at counts 1 and 2 of a ten-step period, away from the wrap, so the moment of hand-over is known exactly.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int unsigned BUS_W     = 32;

   // control word and its alias offsets
   localparam int unsigned OFS_CTRL  = 32'h00;
   localparam int unsigned OFS_SET   = 32'h04;
   localparam int unsigned OFS_CLR   = 32'h08;
   localparam int unsigned OFS_TOG   = 32'h0C;

   // per-channel register pair
   localparam int unsigned OFS_EDGE0 = 32'h10;
   localparam int unsigned OFS_PER0  = 32'h20;
   localparam int unsigned CH_STRIDE = 32'h20;

   // field positions inside the channel registers
   localparam int unsigned HI_LSB    = 16;
   localparam int unsigned LVA_LSB   = 16;
   localparam int unsigned LVI_LSB   = 18;
   localparam int unsigned DIV_LSB   = 20;

   typedef enum logic [1:0] {
      LVL_FLOAT   = 2'd0,
      LVL_LOW_ALT = 2'd1,
      LVL_LOW     = 2'd2,
      LVL_HIGH    = 2'd3
   } lvl_code_e;

   // returns {oe, out}
   function automatic logic [1:0] lvl_drive(lvl_code_e code);
      case (code)
         LVL_FLOAT: return 2'b00;
         LVL_HIGH:  return 2'b11;
         default:   return 2'b10;
      endcase
   endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wen,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [BUS_W-1:0]              bus_wdata,
   output logic [BUS_W-1:0]              bus_rdata,
   output logic [NCH-1:0]                run_o,
   output logic [NCH-1:0][CNT_W-1:0]     act_o,
   output logic [NCH-1:0][CNT_W-1:0]     inact_o,
   output logic [NCH-1:0][CNT_W-1:0]     per_o,
   output logic [NCH-1:0][1:0]           lva_o,
   output logic [NCH-1:0][1:0]           lvi_o,
   output logic [NCH-1:0][DIV_W-1:0]     div_o
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_TOG  = ADDR_W'(OFS_TOG);

   logic [NCH-1:0] ctrl_q;
   logic [NCH-1:0] mask;
   logic           hit_ctrl, hit_set, hit_clr, hit_tog;
   logic [NCH-1:0] hit_edge, hit_per;

   assign mask     = bus_wdata[NCH-1:0];
   assign hit_ctrl = (bus_addr == A_CTRL);
   assign hit_set  = (bus_addr == A_SET);
   assign hit_clr  = (bus_addr == A_CLR);
   assign hit_tog  = (bus_addr == A_TOG);
   assign run_o    = ctrl_q;

   // control word: direct write or masked set / clear / invert
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (bus_wen) begin
         if (hit_ctrl)     ctrl_q <= mask;
         else if (hit_set) ctrl_q <= ctrl_q | mask;
         else if (hit_clr) ctrl_q <= ctrl_q & ~mask;
         else if (hit_tog) ctrl_q <= ctrl_q ^ mask;
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE0 + g * CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PER0 + g * CH_STRIDE);

      logic [CNT_W-1:0] act_r, inact_r, per_r;
      logic [1:0]       lva_r, lvi_r;
      logic [DIV_W-1:0] div_r;

      assign hit_edge[g] = (bus_addr == A_EDGE);
      assign hit_per[g]  = (bus_addr == A_PER);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_r   <= '0;
            inact_r <= '0;
         end else if (bus_wen && hit_edge[g]) begin
            act_r   <= bus_wdata[CNT_W-1:0];
            inact_r <= bus_wdata[HI_LSB +: CNT_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_r <= '0;
            lva_r <= '0;
            lvi_r <= '0;
            div_r <= '0;
         end else if (bus_wen && hit_per[g]) begin
            per_r <= bus_wdata[CNT_W-1:0];
            lva_r <= bus_wdata[LVA_LSB +: 2];
            lvi_r <= bus_wdata[LVI_LSB +: 2];
            div_r <= bus_wdata[DIV_LSB +: DIV_W];
         end
      end

      assign act_o[g]   = act_r;
      assign inact_o[g] = inact_r;
      assign per_o[g]   = per_r;
      assign lva_o[g]   = lva_r;
      assign lvi_o[g]   = lvi_r;
      assign div_o[g]   = div_r;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl || hit_set || hit_clr || hit_tog)
         bus_rdata = BUS_W'(ctrl_q);
      for (int i = 0; i < NCH; i++) begin
         if (hit_edge[i])
            bus_rdata = (BUS_W'(inact_o[i]) << HI_LSB) | BUS_W'(act_o[i]);
         if (hit_per[i])
            bus_rdata = BUS_W'(per_o[i])
                      | (BUS_W'(lva_o[i]) << LVA_LSB)
                      | (BUS_W'(lvi_o[i]) << LVI_LSB)
                      | (BUS_W'(div_o[i]) << DIV_LSB);
      end
   end

   // R3: the alias writes touch only the masked bits
   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wen && hit_set |=> ((ctrl_q & $past(mask)) == $past(mask)));
   p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wen && hit_clr |=> ((ctrl_q & $past(mask)) == '0));
   p_tog_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wen && hit_tog |=> (ctrl_q == ($past(ctrl_q) ^ $past(mask))));
   // R2: a write elsewhere leaves the control word alone
   p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wen && (hit_ctrl || hit_set || hit_clr || hit_tog)) |=> $stable(ctrl_q));

endmodule

// File: rtl/pwm_bank_prescale.sv
module pwm_bank_prescale #(
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] expo,
   output logic             tick
);

   localparam int unsigned PRE_W = (1 << DIV_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   one_sh;
   logic [PRE_W-1:0] lim;

   assign one_sh = (PRE_W + 1)'(1) << expo;
   assign lim    = PRE_W'(one_sh - (PRE_W + 1)'(1));
   assign tick   = run && (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pre_q <= '0;
      else if (!run)  pre_q <= '0;
      else if (tick)  pre_q <= '0;
      else            pre_q <= pre_q + 1'b1;
   end

   // R10: a stopped channel keeps its prescaler at zero
   p_pre_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0));
   // R6: the prescaler never runs past its limit
   p_pre_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pre_q <= lim));

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
   import pwm_bank_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] act_sh,
   input  logic [CNT_W-1:0] inact_sh,
   input  logic [CNT_W-1:0] per_sh,
   input  logic [1:0]       lva_sh,
   input  logic [1:0]       lvi_sh,
   input  logic [DIV_W-1:0] div_sh,
   output logic             pwm_out,
   output logic             pwm_oe
);

   logic [CNT_W-1:0] cnt_q, act_w, inact_w, per_w;
   logic [1:0]       lva_w, lvi_w;
   logic [DIV_W-1:0] div_w;
   logic             tick, at_end, reload, active;
   logic [1:0]       drv;

   pwm_bank_prescale #(.DIV_W(DIV_W)) i_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en),
      .expo  (div_w),
      .tick  (tick)
   );

   assign at_end = (cnt_q == per_w);
   assign reload = !en || (tick && at_end);

   // working copy follows the registers while stopped and at each wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_w   <= '0;
         inact_w <= '0;
         per_w   <= '0;
         lva_w   <= '0;
         lvi_w   <= '0;
         div_w   <= '0;
      end else if (reload) begin
         act_w   <= act_sh;
         inact_w <= inact_sh;
         per_w   <= per_sh;
         lva_w   <= lva_sh;
         lvi_w   <= lvi_sh;
         div_w   <= div_sh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (!en)  cnt_q <= '0;
      else if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   always_comb begin
      active = en && (inact_w != act_w) && (cnt_q >= act_w)
               && ((cnt_q < inact_w) || (inact_w >= per_w));
      drv    = lvl_drive(lvl_code_e'(active ? lva_w : lvi_w));
   end

   assign pwm_oe  = drv[1];
   assign pwm_out = drv[0];

   // R5: the counter wraps to zero after the terminal count
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en && tick && at_end |=> (cnt_q == '0));
   // R6: no step without a prescaler tick
   p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en && !tick |=> $stable(cnt_q));
   // R10: a stopped channel sits at count zero
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));
   // R11: working values change only at a wrap
   p_shadow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      en && !(tick && at_end) |=> ($stable(per_w) && $stable(inact_w) && $stable(act_w)));
   // R7: a floated output never claims a high level
   p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe |-> !pwm_out);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH    = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    pwm_out,
   output logic [NCH-1:0]    pwm_oe
);

   localparam int unsigned LAST_OFS = OFS_PER0 + (NCH - 1) * CH_STRIDE;

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("pwm_bank: NCH must lie in 1..32");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("pwm_bank: CNT_W must lie in 2..16");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("pwm_bank: DIV_W must lie in 1..3");
   end
   if (LAST_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too narrow for NCH channels");
   end

   logic [NCH-1:0]            run;
   logic [NCH-1:0][CNT_W-1:0] act, inact, per;
   logic [NCH-1:0][1:0]       lva, lvi;
   logic [NCH-1:0][DIV_W-1:0] dv;

   pwm_bank_regs #(
      .NCH    (NCH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DIV_W  (DIV_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wen   (bus_wen),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .run_o     (run),
      .act_o     (act),
      .inact_o   (inact),
      .per_o     (per),
      .lva_o     (lva),
      .lvi_o     (lvi),
      .div_o     (dv)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      pwm_bank_chan #(
         .CNT_W (CNT_W),
         .DIV_W (DIV_W)
      ) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (run[g]),
         .act_sh   (act[g]),
         .inact_sh (inact[g]),
         .per_sh   (per[g]),
         .lva_sh   (lva[g]),
         .lvi_sh   (lvi[g]),
         .div_sh   (dv[g]),
         .pwm_out  (pwm_out[g]),
         .pwm_oe   (pwm_oe[g])
      );
   end

endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_wen = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   wire  [31:0]    bus_rdata;
   wire  [NCH-1:0] pwm_out;
   wire  [NCH-1:0] pwm_oe;

   always #5 clk = ~clk;

   pwm_bank i_pwm_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wen   (bus_wen),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out),
      .pwm_oe    (pwm_oe)
   );

   typedef struct {
      int    ch;
      logic  oe;
      logic  lvl;
      string req;
   } item_t;

   item_t sb_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;

   task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // R7 encoding, returns {oe, out}
   function automatic logic [1:0] lvl_of(int code);
      case (code)
         0:       return 2'b00;
         3:       return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   // R5, R8, R9 phase rule
   function automatic bit phase_on(int cnt, int a, int ia, int p);
      if (ia == a) return 1'b0;
      return (cnt >= a) && ((cnt < ia) || (ia >= p));
   endfunction

   function automatic logic [7:0] edge_ofs(int ch);
      return 8'(8'h10 + 8'h20 * ch);
   endfunction

   function automatic logic [7:0] per_ofs(int ch);
      return 8'(8'h20 + 8'h20 * ch);
   endfunction

   function automatic logic [31:0] per_word(int p, int la, int li, int e);
      return (32'(e) << 20) | (32'(li) << 18) | (32'(la) << 16) | 32'(p);
   endfunction

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wen   = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wen   = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_wen  = 1'b0;
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // driver side of the scoreboard: expected {oe,out} for cycles i0..i1
   task automatic push_seg(int ch, int i0, int i1, int base, int a, int ia, int p,
                           int la, int li, int e, string req);
      for (int i = i0; i <= i1; i++) begin
         item_t it;
         int    cnt;
         logic [1:0] d;
         cnt    = ((i - base) >> e) % (p + 1);
         d      = lvl_of(phase_on(cnt, a, ia, p) ? la : li);
         it.ch  = ch;
         it.oe  = d[1];
         it.lvl = d[0];
         it.req = req;
         sb_q.push_back(it);
      end
   endtask

   // monitor side: one comparison per cycle, away from the clock edge
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         item_t it;
         it = sb_q.pop_front();
         check_val(it.req, $sformatf("ch%0d {oe,out}", it.ch),
                   32'({pwm_oe[it.ch], pwm_out[it.ch]}), 32'({it.oe, it.lvl}));
      end
   end

   task automatic wait_drain();
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   task automatic stop_and_check(int ch, int li);
      logic [1:0] d;
      wr(8'h08, 32'(1) << ch);
      #1;
      d = lvl_of(li);
      // R10: stopped channel drives its inactive level
      check_val("R10", $sformatf("ch%0d stopped {oe,out}", ch),
                32'({pwm_oe[ch], pwm_out[ch]}), 32'(d));
   endtask

   task automatic run_wave(int ch, int a, int ia, int p, int la, int li, int e,
                           int n, string req);
      wr(edge_ofs(ch), (32'(ia) << 16) | 32'(a));
      wr(per_ofs(ch), per_word(p, la, li, e));
      @(negedge clk);
      bus_wen   = 1'b1;
      bus_addr  = 8'h04;
      bus_wdata = 32'(1) << ch;
      @(posedge clk);
      #1;
      push_seg(ch, 0, n - 1, 0, a, ia, p, la, li, e, req);
      @(negedge clk);
      bus_wen = 1'b0;
      wait_drain();
      stop_and_check(ch, li);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(8'h00, v); check_val("R1", "ctrl after reset", v, 32'h0);
      for (int c = 0; c < NCH; c++) begin
         rd(edge_ofs(c), v); check_val("R1", $sformatf("edge%0d after reset", c), v, 32'h0);
         rd(per_ofs(c), v);  check_val("R1", $sformatf("per%0d after reset", c), v, 32'h0);
      end
      check_val("R1", "pwm_oe after reset", 32'(pwm_oe), 32'h0);

      // R4: register readback and field layout
      wr(edge_ofs(2), 32'hABCD_1234);
      rd(edge_ofs(2), v); check_val("R4", "edge2 readback", v, 32'hABCD_1234);
      wr(per_ofs(2), 32'hFFFF_FFFF);
      rd(per_ofs(2), v);  check_val("R4", "per2 readback", v, 32'h007F_FFFF);
      #1;
      // R10: stopped channel with inactive code 3 drives high
      check_val("R10", "ch2 stopped code3", 32'({pwm_oe[2], pwm_out[2]}), 32'h3);

      // R2: direct control writes
      wr(8'h00, 32'h5);
      rd(8'h00, v); check_val("R2", "ctrl direct", v, 32'h5);
      wr(8'h00, 32'hFFFF_FFF0);
      rd(8'h00, v); check_val("R2", "ctrl upper bits", v, 32'h0);

      // R3: alias writes and alias reads
      wr(8'h00, 32'h5);
      wr(8'h04, 32'h2);
      rd(8'h00, v); check_val("R3", "set alias", v, 32'h7);
      wr(8'h08, 32'h5);
      rd(8'h00, v); check_val("R3", "clear alias", v, 32'h2);
      wr(8'h0C, 32'h3);
      rd(8'h00, v); check_val("R3", "toggle alias", v, 32'h1);
      rd(8'h04, v); check_val("R3", "read set alias", v, 32'h1);
      rd(8'h08, v); check_val("R3", "read clear alias", v, 32'h1);
      rd(8'h0C, v); check_val("R3", "read toggle alias", v, 32'h1);
      wr(8'h00, 32'h0);

      // R5: basic waveform, high active, low inactive
      run_wave(0, 0, 3, 7, 3, 2, 0, 24, "R5");
      // R6: prescaler exponent 2 with inverted levels and nonzero active edge
      run_wave(1, 1, 4, 5, 2, 3, 2, 48, "R6");
      // R8: inactive edge beyond the terminal count
      run_wave(2, 0, 9, 6, 3, 2, 1, 28, "R8");
      // R8: inactive edge equal to the terminal count
      run_wave(2, 0, 6, 6, 3, 2, 0, 14, "R8");
      // R9: equal edges give zero duty
      run_wave(3, 2, 2, 5, 3, 2, 0, 12, "R9");
      // R7: code 1 drives low, code 0 floats
      run_wave(0, 0, 2, 4, 1, 0, 0, 15, "R7");
      // R6: largest exponent
      run_wave(1, 0, 1, 1, 3, 2, 7, 512, "R6");

      // R11: writes during a running period take effect at the wrap
      wr(edge_ofs(0), (32'd4 << 16) | 32'd0);
      wr(per_ofs(0), per_word(9, 3, 2, 0));
      @(negedge clk);
      bus_wen   = 1'b1;
      bus_addr  = 8'h04;
      bus_wdata = 32'h1;
      @(posedge clk);
      #1;
      push_seg(0, 0, 9, 0, 0, 4, 9, 3, 2, 0, "R11");
      push_seg(0, 10, 17, 10, 0, 1, 3, 3, 2, 0, "R11");
      @(negedge clk);
      bus_addr  = edge_ofs(0);
      bus_wdata = (32'd1 << 16) | 32'd0;
      @(negedge clk);
      bus_addr  = per_ofs(0);
      bus_wdata = per_word(3, 3, 2, 0);
      @(negedge clk);
      bus_wen = 1'b0;
      wait_drain();
      rd(per_ofs(0), v); check_val("R4", "per0 new value", v, per_word(3, 3, 2, 0));
      stop_and_check(0, 2);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule